// File: doc/BRIEF.md
# Prioritized Per-Packet Interrupt Register

This block is a read-only interrupt status register for a repeater with up to sixteen ports. While a packet is being repeated, the port logic reports four kinds of event. A port can see its frame's source address disagree with the learned one. One port is the receive source. A port can be the first to see a collision. Ports can be partitioned or reconnected. The block captures these events as pending interrupts. A host reads them out one at a time. Each read returns the most urgent pending event and then retires it.

Every read word has two fields. The upper nibble carries the port address. The lower nibble carries an active-low source code with one bit per event kind. When nothing reportable is pending, the word is all ones. Partition and reconnection events can pile up on several ports within one packet. These are served round-robin, beginning at the port after the last one reported. When the next packet starts transmitting, everything still pending is dropped. The read strobe is a level. The word is captured when the strobe rises and held while it stays high. The retire happens when the strobe falls.

Top module: `irq_vector_reg`

## Requirements
- R1: Read data carries the port address in bits 7:4 and an active-low source code in bits 3:0, with exactly one bit low: bit 0 low = receive (code 4'hE), bit 1 low = first collision (4'hD), bit 2 low = partition/reconnection (4'hB), bit 3 low = source address mismatch (4'h7).
- R2: When several kinds are pending, mismatch is reported before receive, receive before collision, and collision before partition/reconnection.
- R3: A read with no reportable event pending returns 8'hFF.
- R4: The falling edge of a read strobe retires the one event that the read reported, whatever its kind; other pending events remain.
- R5: A pulse on `pkt_start` discards every pending event. A read whose strobe spans that pulse retires nothing from the new packet. Events presented in the same cycle as the pulse belong to the new packet and are kept.
- R6: Only the first collision of a packet is recorded. Later collisions in the same packet, on any port, are ignored, even after the first has been read.
- R7: Partition/reconnection events are kept per port. They are served by scanning upward from a pointer, wrapping from port NPORTS-1 to port 0. After each such report, the pointer moves to the port after the one reported. The pointer is 0 after reset.
- R8: `src_mask` bit k (same bit numbering as the R1 code) set to 1 blocks capture of that kind. It also hides any already-pending event of that kind from reads while set.
- R9: A second receive or mismatch event within the same packet creates no new pending entry, even after the first has been read.
- R10: Read data is captured on the first cycle the strobe is high and stays unchanged while it is held. An event arriving while a read is in progress, including on the cycle its retire takes effect, is not lost.
- R11: After reset nothing is pending, read data is 8'hFF, and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Pulse when the next packet begins transmission; flushes pending events |
| src_mask | input | 4 | Per-kind mask, bit order as the source code (1 = masked) |
| mis_evt | input | 1 | Source address mismatch event |
| mis_pa | input | 4 | Port of the mismatch |
| rx_evt | input | 1 | Receive-source event |
| rx_pa | input | 4 | Receiving port |
| col_evt | input | 1 | Collision event |
| col_pa | input | 4 | Colliding port |
| part_evt | input | NPORTS | Per-port partition/reconnection pulses |
| rd_strobe | input | 1 | Host read strobe (level) |
| rd_data | output | 8 | {port address, active-low source code} |

## Verification
Suppose the round-robin pointer lands on the wrong port. The next read that reports a partition or reconnection then shows a port address out of sequence. This is visible as early as the second partition read of a packet. A stale single-event flag that survives a packet boundary shows up as a missing or extra report on the first read after the next `pkt_start`. A retire aimed at the wrong entry shows up on the read after it, as a repeated word or a skipped one. Capture-timing faults appear within a single held strobe: a changing word, or an event injected mid-read that never comes out.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;

    localparam int PA_W  = 4;
    localparam int SRC_W = 4;
    localparam int RD_W  = PA_W + SRC_W;

    // enum value doubles as the low bit position in the source code
    typedef enum logic [1:0] {
        K_RX   = 2'd0,
        K_COL  = 2'd1,
        K_PART = 2'd2,
        K_MIS  = 2'd3
    } irq_kind_e;

    typedef struct packed {
        logic            valid;
        irq_kind_e       kind;
        logic [PA_W-1:0] pa;
    } irq_sel_t;

    localparam logic [RD_W-1:0] NO_IRQ = '1;

    function automatic logic [SRC_W-1:0] src_code(irq_kind_e k);
        return ~(SRC_W'(1) << k);
    endfunction

    function automatic logic [RD_W-1:0] pack_rd(irq_sel_t s);
        if (!s.valid) return NO_IRQ;
        return {s.pa, src_code(s.kind)};
    endfunction

endpackage

// File: rtl/irq_slot.sv
module irq_slot
    import pkt_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            evt,
    input  logic [PA_W-1:0] evt_pa,
    input  logic            masked,
    input  logic            clr,
    output logic            pend,
    output logic [PA_W-1:0] pa
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            seen_q <= 1'b0;
            pa     <= '0;
        end else begin
            if (flush) begin
                pend   <= 1'b0;
                seen_q <= 1'b0;
            end else if (clr) begin
                pend <= 1'b0;
            end
            if (evt && !masked && (flush || !seen_q)) begin
                pend   <= 1'b1;
                seen_q <= 1'b1;
                pa     <= evt_pa;
            end
        end
    end

    // once an event is taken in a packet, its port is frozen until the flush
    p_first_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!flush && seen_q) |=> $stable(pa));

    p_no_repend_r9: assert property (@(posedge clk) disable iff (rst)
        (!flush && seen_q && !pend) |=> !pend);

    p_flush_r5: assert property (@(posedge clk) disable iff (rst)
        (flush && !evt) |=> !pend);

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick
    import pkt_irq_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic [NPORTS-1:0] req,
    input  logic [PA_W-1:0]   ptr,
    output logic              hit,
    output logic [PA_W-1:0]   idx
);

    // lowest offset from ptr wins, so walk offsets downward and overwrite
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            int j;
            j = (int'(ptr) + i) % NPORTS;
            if (req[j]) begin
                hit = 1'b1;
                idx = PA_W'(j);
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import pkt_irq_pkg::*;
(
    input  logic [SRC_W-1:0] mask,
    input  logic             mis_pend,
    input  logic [PA_W-1:0]  mis_pa,
    input  logic             rx_pend,
    input  logic [PA_W-1:0]  rx_pa,
    input  logic             col_pend,
    input  logic [PA_W-1:0]  col_pa,
    input  logic             part_hit,
    input  logic [PA_W-1:0]  part_pa,
    output irq_sel_t         sel
);

    // later assignments override earlier ones: mismatch ends up on top
    always_comb begin
        sel = '0;
        if (part_hit && !mask[K_PART]) sel = '{1'b1, K_PART, part_pa};
        if (col_pend && !mask[K_COL])  sel = '{1'b1, K_COL,  col_pa};
        if (rx_pend  && !mask[K_RX])   sel = '{1'b1, K_RX,   rx_pa};
        if (mis_pend && !mask[K_MIS])  sel = '{1'b1, K_MIS,  mis_pa};
    end

endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
    import pkt_irq_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic [SRC_W-1:0]  src_mask,
    input  logic              mis_evt,
    input  logic [PA_W-1:0]   mis_pa,
    input  logic              rx_evt,
    input  logic [PA_W-1:0]   rx_pa,
    input  logic              col_evt,
    input  logic [PA_W-1:0]   col_pa,
    input  logic [NPORTS-1:0] part_evt,
    input  logic              rd_strobe,
    output logic [RD_W-1:0]   rd_data
);

    logic              rd_q;
    irq_sel_t          held_q;
    irq_sel_t          cur_sel;
    logic [PA_W-1:0]   ptr_q;
    logic [PA_W-1:0]   ptr_nxt;
    logic [NPORTS-1:0] part_q;
    logic              part_hit;
    logic [PA_W-1:0]   part_pa;
    logic              mis_pend, rx_pend, col_pend;
    logic [PA_W-1:0]   mis_pa_q, rx_pa_q, col_pa_q;

    logic rd_rise, rd_fall, clr_go;
    assign rd_rise = rd_strobe & ~rd_q;
    assign rd_fall = ~rd_strobe & rd_q;
    assign clr_go  = rd_fall & held_q.valid;

    irq_slot u_mis (
        .clk(clk), .rst(rst), .flush(pkt_start),
        .evt(mis_evt), .evt_pa(mis_pa), .masked(src_mask[K_MIS]),
        .clr(clr_go && held_q.kind == K_MIS),
        .pend(mis_pend), .pa(mis_pa_q)
    );

    irq_slot u_rx (
        .clk(clk), .rst(rst), .flush(pkt_start),
        .evt(rx_evt), .evt_pa(rx_pa), .masked(src_mask[K_RX]),
        .clr(clr_go && held_q.kind == K_RX),
        .pend(rx_pend), .pa(rx_pa_q)
    );

    irq_slot u_col (
        .clk(clk), .rst(rst), .flush(pkt_start),
        .evt(col_evt), .evt_pa(col_pa), .masked(src_mask[K_COL]),
        .clr(clr_go && held_q.kind == K_COL),
        .pend(col_pend), .pa(col_pa_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_part
        always_ff @(posedge clk) begin
            if (rst) begin
                part_q[p] <= 1'b0;
            end else begin
                if (pkt_start)
                    part_q[p] <= 1'b0;
                else if (clr_go && held_q.kind == K_PART && held_q.pa == PA_W'(p))
                    part_q[p] <= 1'b0;
                if (part_evt[p] && !src_mask[K_PART])
                    part_q[p] <= 1'b1;
            end
        end

        // a fresh event beats a retire landing on the same port
        p_evt_kept_r10: assert property (@(posedge clk) disable iff (rst)
            (part_evt[p] && !src_mask[K_PART]) |=> part_q[p]);
    end

    irq_rr_pick #(.NPORTS(NPORTS)) u_rr (
        .req(part_q), .ptr(ptr_q), .hit(part_hit), .idx(part_pa)
    );

    irq_prio_sel u_sel (
        .mask(src_mask),
        .mis_pend(mis_pend), .mis_pa(mis_pa_q),
        .rx_pend(rx_pend),   .rx_pa(rx_pa_q),
        .col_pend(col_pend), .col_pa(col_pa_q),
        .part_hit(part_hit), .part_pa(part_pa),
        .sel(cur_sel)
    );

    always_comb
        ptr_nxt = (int'(held_q.pa) + 1 >= NPORTS) ? '0 : held_q.pa + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            held_q  <= '0;
            rd_data <= NO_IRQ;
            ptr_q   <= '0;
        end else begin
            rd_q <= rd_strobe;
            if (rd_rise) begin
                held_q       <= cur_sel;
                held_q.valid <= cur_sel.valid && !pkt_start;
                rd_data      <= pack_rd(cur_sel);
            end else if (rd_fall || pkt_start) begin
                held_q.valid <= 1'b0;
            end
            if (clr_go && held_q.kind == K_PART)
                ptr_q <= ptr_nxt;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        rd_q |=> $stable(rd_data));

    p_code_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~rd_data[SRC_W-1:0]) <= 1);

    p_none_ff_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[SRC_W-1:0] == '1) |-> (rd_data[RD_W-1:SRC_W] == '1));

    p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && src_mask == '1) |=> (rd_data == NO_IRQ));

    p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < NPORTS);

endmodule

// File: tb/irq_vector_reg_bench.sv
module irq_vector_reg_bench;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_start = 1'b0;
    logic [3:0]    src_mask = 4'h0;
    logic          mis_evt = 1'b0, rx_evt = 1'b0, col_evt = 1'b0;
    logic [3:0]    mis_pa = 4'h0, rx_pa = 4'h0, col_pa = 4'h0;
    logic [NP-1:0] part_evt = '0;
    logic          rd_strobe = 1'b0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_vector_reg #(.NPORTS(NP)) u_irq_vector_reg (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .src_mask(src_mask),
        .mis_evt(mis_evt), .mis_pa(mis_pa), .rx_evt(rx_evt), .rx_pa(rx_pa),
        .col_evt(col_evt), .col_pa(col_pa), .part_evt(part_evt),
        .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    // {newpkt, mis, misp, rx, rxp, col, colp, part[15:0], mask, pad, expected}
    function automatic logic [47:0] mkv(logic np, logic m, logic [3:0] mp,
                                        logic r, logic [3:0] rp, logic c, logic [3:0] cp,
                                        logic [15:0] pt, logic [3:0] mk, logic [7:0] ex);
        return {np, m, mp, r, rp, c, cp, pt, mk, 4'h0, ex};
    endfunction

    localparam int NV = 16;
    localparam logic [47:0] VEC [NV] = '{
        mkv(1, 0, 0, 1, 5, 0, 0, 16'h0000, 4'h0, 8'h5E), // R1 receive p5
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'hFF), // R4 retired, R3 empty
        mkv(1, 1, 2, 1, 7, 1, 9, 16'h0010, 4'h0, 8'h27), // R2 mismatch first
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'h7E), // R2 receive next
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'h9D), // R2 collision next
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'h4B), // R2 partition last
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'hFF), // R3
        mkv(1, 0, 0, 0, 0, 0, 0, 16'h1208, 4'h0, 8'h9B), // R7 ptr=5 -> p9
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'hCB), // R7 p12
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'h3B), // R7 wrap to p3
        mkv(0, 0, 0, 0, 0, 0, 0, 16'h0000, 4'h0, 8'hFF), // R7 drained
        mkv(1, 0, 0, 0, 0, 1, 6, 16'h0000, 4'h0, 8'h6D), // R6 first collision
        mkv(0, 0, 0, 0, 0, 1, 11, 16'h0000, 4'h0, 8'hFF), // R6 later collision ignored
        mkv(1, 0, 0, 1, 1, 0, 0, 16'h0000, 4'h1, 8'hFF), // R8 masked receive
        mkv(1, 1, 3, 0, 0, 0, 0, 16'h0000, 4'h0, 8'h37), // R1 mismatch code
        mkv(0, 1, 8, 0, 0, 0, 0, 16'h0000, 4'h0, 8'hFF)  // R9 repeat mismatch
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) v = rd_data; rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic new_packet();
        @(negedge clk) pkt_start = 1'b1;
        @(negedge clk) pkt_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset data", rd_data, 8'hFF);
        do_read(v);
        check("R11 reset read", v, 8'hFF);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            pkt_start = VEC[k][47];
            mis_evt = VEC[k][46]; mis_pa = VEC[k][45:42];
            rx_evt  = VEC[k][41]; rx_pa  = VEC[k][40:37];
            col_evt = VEC[k][36]; col_pa = VEC[k][35:32];
            part_evt = VEC[k][31:16];
            src_mask = VEC[k][15:12];
            @(negedge clk);
            pkt_start = 0; mis_evt = 0; rx_evt = 0; col_evt = 0; part_evt = '0;
            do_read(v);
            check($sformatf("vector %0d", k), v, VEC[k][7:0]);
        end
        src_mask = 4'h0;

        // R6: two colliders back to back, only the first is kept
        new_packet();
        @(negedge clk) col_evt = 1; col_pa = 4'd2;
        @(negedge clk) col_pa = 4'd7;
        @(negedge clk) col_evt = 0;
        do_read(v); check("R6 first collider", v, 8'h2D);
        do_read(v); check("R6 second collider dropped", v, 8'hFF);

        // R5: flush discards an unread event
        @(negedge clk) rx_evt = 1; rx_pa = 4'd4;
        @(negedge clk) rx_evt = 0;
        new_packet();
        do_read(v); check("R5 flushed", v, 8'hFF);

        // R10: stable hold and event injected mid-read
        @(negedge clk) pkt_start = 1; rx_evt = 1; rx_pa = 4'd6;
        @(negedge clk) pkt_start = 0; rx_evt = 0;
        @(negedge clk) rd_strobe = 1;
        @(negedge clk) check("R10 captured", rd_data, 8'h6E);
        mis_evt = 1; mis_pa = 4'd1;
        @(negedge clk) mis_evt = 0;
        check("R10 held", rd_data, 8'h6E);
        rd_strobe = 0;
        @(negedge clk);
        do_read(v); check("R10 mid-read event kept", v, 8'h17);
        do_read(v); check("R4 both retired", v, 8'hFF);

        // R10: retire and new event on the same port and cycle (ptr=4 here)
        @(negedge clk) pkt_start = 1; part_evt[10] = 1;
        @(negedge clk) pkt_start = 0; part_evt = '0;
        @(negedge clk) rd_strobe = 1;
        @(negedge clk) v = rd_data; rd_strobe = 0; part_evt[10] = 1;
        check("R7 partition p10", v, 8'hAB);
        @(negedge clk) part_evt = '0;
        do_read(v); check("R10 same-cycle event kept", v, 8'hAB);
        do_read(v); check("R10 drained", v, 8'hFF);

        // R8: mask applied after capture hides the event
        @(negedge clk) pkt_start = 1; rx_evt = 1; rx_pa = 4'd9;
        @(negedge clk) pkt_start = 0; rx_evt = 0; src_mask = 4'h1;
        do_read(v); check("R8 hidden by mask", v, 8'hFF);
        src_mask = 4'h0;
        do_read(v); check("R8 unmasked again", v, 8'h9E);

        // R5: packet start during a held read retires nothing of the new packet
        @(negedge clk) pkt_start = 1; rx_evt = 1; rx_pa = 4'd3;
        @(negedge clk) pkt_start = 0; rx_evt = 0;
        @(negedge clk) rd_strobe = 1;
        @(negedge clk) check("R5 old word", rd_data, 8'h3E);
        pkt_start = 1; rx_evt = 1; rx_pa = 4'd5;
        @(negedge clk) pkt_start = 0; rx_evt = 0; rd_strobe = 0;
        @(negedge clk);
        do_read(v); check("R5 new packet event survives", v, 8'h5E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule